// File: doc/BRIEF.md
# PATA PIO Strobe Timing Engine

This block turns single host accesses into Parallel ATA PIO bus cycles toward a CompactFlash card working in True IDE mode. Three programmable counts, all in clock cycles, set the access: strobe setup, strobe pulse and total cycle length. The engine corrects them before use. The strobe starts one cycle later than programmed, to let ringing settle. The cycle is stretched when fewer than two recovery cycles would remain after the strobe. Chip select is placed one cycle inside each end of the access. Reads and writes share one timing set; only the strobe line differs between them.

The host address picks one of two windows. The lower window reaches the task-file registers through the first chip select. The upper window, selected by one high address bit, reaches device control and alternate status (register index 6) through the second chip select. Host addresses are even. Register index bits come from host address bits [3:1], so 8-bit register values always travel on the low byte of the 16-bit data bus.

A level request is answered by a one-cycle acknowledge once the whole bus cycle, recovery included, has finished. A device ready input lengthens the strobe while it is low. Timing writes made during an access take effect at the start of the next access.

Top module: `pata_pio_engine`

## Requirements
- R1: After reset the chip selects, both strobes and the acknowledge are inactive and the data bus is not driven. The timing counts hold PIO mode 0 values rounded up to whole clocks: setup 70 ns, pulse 290 ns, cycle 600 ns. At the default 4 ns clock these are 18, 73 and 150 cycles.
- R2: Cycle 0 is the first clock after an accepted request. The strobe asserts in cycle setup+1.
- R3: With ready high, the strobe stays low for pulse cycles. A programmed pulse of 0 acts as 1.
- R4: The access lasts C = max(cycle, setup+1+pulse+2) cycles. The acknowledge is high for one clock, in cycle C.
- R5: The active chip select goes low in cycle 1 and stays low for C-2 cycles.
- R6: With host address bit 21 clear, cs0_n is driven low and cs1_n stays high. With bit 21 set, cs1_n is driven low and cs0_n stays high.
- R7: The register address output equals host address bits [3:1] throughout the access.
- R8: A read returns the data bus value present in the last cycle the read strobe is low. That value is held on host_rdata after the acknowledge.
- R9: Ready is checked in the last strobe cycle. Each cycle it is low there stretches the strobe, the chip select and the access by one cycle.
- R10: A write uses the same timing on the write strobe. The bus is driven with the host write data from strobe assertion until the chip select rises. Reads never drive the bus.
- R11: Timing writes (select 0 setup, 1 pulse, 2 cycle) made during an access do not alter it but apply from the next access. Select 3 is ignored.
- R12: The acknowledge is a single-cycle pulse. The request is sampled again only in the cycle after it.
- R13: The two strobes are never low together, and the two chip selects are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Timing register select |
| cfg_wdata | input | 8 | Timing count in cycles |
| host_req | input | 1 | Access request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Host byte address |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Captured read data |
| ide_cs0_n | output | 1 | Task-file chip select |
| ide_cs1_n | output | 1 | Control-block chip select |
| ide_da | output | 3 | Register address |
| ide_dior_n | output | 1 | Read strobe |
| ide_diow_n | output | 1 | Write strobe |
| ide_iordy | input | 1 | Device ready, synchronous to clk |
| ide_dd_in | input | 16 | Data bus input |
| ide_dd_out | output | 16 | Data bus output |
| ide_dd_oe | output | 1 | Data bus output enable |

## Verification
The assertions assume that ide_iordy is already synchronous to clk. They also assume the host holds its request, address, direction and write data steady from the request until the acknowledge. The stimulus drives ready only at the falling edge and keeps it low only inside the last strobe cycle, for a bounded number of cycles. It changes the request fields only at the acknowledge. Random timing counts stay small, so many short accesses fit the run, while the reset PIO mode 0 access covers the long case.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  parameter int unsigned CFG_W  = 8;
  parameter int unsigned DATA_W = 16;
  localparam int unsigned CNT_W = CFG_W + 2;

  typedef enum logic [1:0] {
    SEL_SETUP = 2'd0,
    SEL_PULSE = 2'd1,
    SEL_CYCLE = 2'd2
  } cfg_sel_e;

  // Derived, already-adjusted positions within one access
  typedef struct packed {
    logic [CNT_W-1:0] strobe_on;   // first strobe cycle
    logic [CNT_W-1:0] strobe_off;  // first cycle after the strobe
    logic [CNT_W-1:0] cycle_len;   // total cycles of the access
  } timing_t;
endpackage

// File: rtl/pata_pio_timing.sv
module pata_pio_timing
  import pata_pio_pkg::*;
#(
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned SETUP_NS = 70,
  parameter int unsigned ACT_NS   = 290,
  parameter int unsigned CYC_NS   = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output timing_t          tim
);
  localparam int unsigned RST_SET = (SETUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned RST_PUL = (ACT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int unsigned RST_CYC = (CYC_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic [CFG_W-1:0] set_q, pul_q, cyc_q;
  logic             set_en, pul_en, cyc_en;
  logic [CNT_W-1:0] pul_eff, on_w, off_w, min_cyc, cyc_w;

  always_comb begin
    set_en = cfg_we && (cfg_sel == SEL_SETUP);
    pul_en = cfg_we && (cfg_sel == SEL_PULSE);
    cyc_en = cfg_we && (cfg_sel == SEL_CYCLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= CFG_W'(RST_SET);
      pul_q <= CFG_W'(RST_PUL);
      cyc_q <= CFG_W'(RST_CYC);
    end else begin
      if (set_en) set_q <= cfg_wdata;
      if (pul_en) pul_q <= cfg_wdata;
      if (cyc_en) cyc_q <= cfg_wdata;
    end
  end

  // Adjustment: one extra setup cycle, pulse of at least 1, two recovery cycles
  always_comb begin
    pul_eff = (pul_q == '0) ? CNT_W'(1) : CNT_W'(pul_q);
    on_w    = CNT_W'(set_q) + CNT_W'(1);
    off_w   = on_w + pul_eff;
    min_cyc = off_w + CNT_W'(2);
    cyc_w   = (CNT_W'(cyc_q) < min_cyc) ? min_cyc : CNT_W'(cyc_q);
    tim.strobe_on  = on_w;
    tim.strobe_off = off_w;
    tim.cycle_len  = cyc_w;
  end
endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
  import pata_pio_pkg::*;
#(
  parameter int unsigned AW      = 22,
  parameter int unsigned WIN_BIT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  input  timing_t           tim,
  input  logic              ide_iordy,
  input  logic [DATA_W-1:0] ide_dd_in,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt,
  output timing_t           tim_act,
  output logic              we_act,
  output logic              win_act,
  output logic [2:0]        da_act,
  output logic [DATA_W-1:0] wd_act
);
  logic              busy_q, busy_d, ack_q, ack_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  timing_t           tim_q;
  logic              we_q, win_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              start, last_strobe, stall, end_cyc, cap_en;
  logic              unused_addr;

  assign unused_addr = ^{host_addr[AW-1:WIN_BIT+1], host_addr[WIN_BIT-1:4], host_addr[0]};

  always_comb begin
    start       = !busy_q && !ack_q && host_req;
    last_strobe = busy_q && (cnt_q == tim_q.strobe_off - CNT_W'(1));
    stall       = last_strobe && !ide_iordy;
    end_cyc     = busy_q && (cnt_q == tim_q.cycle_len - CNT_W'(1));
    cap_en      = last_strobe && ide_iordy && !we_q;
    busy_d      = busy_q;
    cnt_d       = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (end_cyc) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q && !stall) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
    ack_d = end_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= '0;
      we_q  <= 1'b0;
      win_q <= 1'b0;
      da_q  <= '0;
      wd_q  <= '0;
    end else if (start) begin
      tim_q <= tim;
      we_q  <= host_we;
      win_q <= host_addr[WIN_BIT];
      da_q  <= host_addr[3:1];
      wd_q  <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= ide_dd_in;
  end

  assign host_ack   = ack_q;
  assign host_rdata = rd_q;
  assign busy       = busy_q;
  assign cnt        = cnt_q;
  assign tim_act    = tim_q;
  assign we_act     = we_q;
  assign win_act    = win_q;
  assign da_act     = da_q;
  assign wd_act     = wd_q;

  // R12
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  // R4
  recovery_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tim_q.cycle_len >= tim_q.strobe_off + CNT_W'(2)));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !host_ack && !ide_iordy && last_strobe) |=> (busy_q && $stable(cnt_q)));
endmodule

// File: rtl/pata_pio_pins.sv
module pata_pio_pins
  import pata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  timing_t           tim_act,
  input  logic              we_act,
  input  logic              win_act,
  input  logic [2:0]        da_act,
  input  logic [DATA_W-1:0] wd_act,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic [2:0]        ide_da,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [DATA_W-1:0] ide_dd_out,
  output logic              ide_dd_oe
);
  logic cs_on, strb_on, drive_on;

  always_comb begin
    cs_on    = busy && (cnt >= CNT_W'(1)) && (cnt < tim_act.cycle_len - CNT_W'(1));
    strb_on  = busy && (cnt >= tim_act.strobe_on) && (cnt < tim_act.strobe_off);
    drive_on = busy && we_act && (cnt >= tim_act.strobe_on)
               && (cnt < tim_act.cycle_len - CNT_W'(1));
    ide_cs0_n  = !(cs_on && !win_act);
    ide_cs1_n  = !(cs_on && win_act);
    ide_dior_n = !(strb_on && !we_act);
    ide_diow_n = !(strb_on && we_act);
    ide_da     = da_act;
    ide_dd_out = wd_act;
    ide_dd_oe  = drive_on;
  end

  // R13
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ide_cs0_n || ide_cs1_n);
  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dior_n || ide_diow_n);
  // R5
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n || !ide_diow_n) |-> (!ide_cs0_n || !ide_cs1_n));
  // R10
  oe_at_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_diow_n |-> ide_dd_oe);
  // R10
  no_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_dior_n |-> !ide_dd_oe);
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pio_pkg::*;
#(
  parameter int unsigned AW       = 22,
  parameter int unsigned WIN_BIT  = 21,
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned SETUP_NS = 70,
  parameter int unsigned ACT_NS   = 290,
  parameter int unsigned CYC_NS   = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic [2:0]        ide_da,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  input  logic              ide_iordy,
  input  logic [DATA_W-1:0] ide_dd_in,
  output logic [DATA_W-1:0] ide_dd_out,
  output logic              ide_dd_oe
);
  timing_t           tim, tim_act;
  logic              busy, we_act, win_act;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        da_act;
  logic [DATA_W-1:0] wd_act;

  pata_pio_timing #(
    .CLK_PS(CLK_PS), .SETUP_NS(SETUP_NS), .ACT_NS(ACT_NS), .CYC_NS(CYC_NS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tim(tim)
  );

  pata_pio_seq #(.AW(AW), .WIN_BIT(WIN_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .tim(tim), .ide_iordy(ide_iordy),
    .ide_dd_in(ide_dd_in), .busy(busy), .cnt(cnt), .tim_act(tim_act),
    .we_act(we_act), .win_act(win_act), .da_act(da_act), .wd_act(wd_act)
  );

  pata_pio_pins u_pins (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt), .tim_act(tim_act),
    .we_act(we_act), .win_act(win_act), .da_act(da_act), .wd_act(wd_act),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n), .ide_da(ide_da),
    .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe)
  );
endmodule

// File: tb/pata_pio_engine_tb.sv
module pata_pio_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [21:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic        ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe;
  logic [2:0]  ide_da;
  logic        ide_iordy = 1'b1;
  logic [15:0] ide_dd_in = '0;
  logic [15:0] ide_dd_out;

  int n_chk = 0, n_bad = 0;
  int m_set = 18, m_pul = 73, m_cyc = 150;

  always #2 clk = ~clk;

  pata_pio_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
    .ide_da(ide_da), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
    .ide_iordy(ide_iordy), .ide_dd_in(ide_dd_in), .ide_dd_out(ide_dd_out),
    .ide_dd_oe(ide_dd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_on();  return m_set + 1; endfunction
  function automatic int f_pul(); return (m_pul == 0) ? 1 : m_pul; endfunction
  function automatic int f_cyc();
    int a = f_on() + f_pul();
    return (m_cyc < a + 2) ? a + 2 : m_cyc;
  endfunction

  task automatic cfg_write(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 0) m_set = val;
    else if (sel == 1) m_pul = val;
    else if (sel == 2) m_cyc = val;
  endtask

  task automatic access(input bit we, input int addr, input int wd,
                        input int w, input bit midcfg);
    int s = f_on(), p = f_pul(), c = f_cyc();
    int stb_first = -1, stb_cnt = 0, cs_first = -1, cs_cnt = 0;
    int oe_first = -1, oe_cnt = 0, wrong = 0, da_bad = 0, cs_bad = 0, dout_bad = 0;
    int ack_idx = -1, idx = 0, nset = 0, npul = 0, ncyc = 0;
    logic [15:0] last_v = '0;
    bit alt = addr[21];
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr[21:0]; host_wdata = wd[15:0];
    if (midcfg) begin
      nset = $urandom_range(0, 5); npul = $urandom_range(1, 6); ncyc = $urandom_range(0, 20);
    end
    while (ack_idx < 0 && idx < 3000) begin
      @(negedge clk);
      if (host_ack) begin
        ack_idx = idx;
        host_req = 1'b0;
      end
      if ((we ? ide_diow_n : ide_dior_n) == 1'b0) begin
        if (stb_first < 0) stb_first = idx;
        stb_cnt++;
      end
      if ((we ? ide_dior_n : ide_diow_n) == 1'b0) wrong++;
      if (!ide_cs0_n || !ide_cs1_n) begin
        if (cs_first < 0) cs_first = idx;
        cs_cnt++;
        if (ide_cs0_n != alt || ide_cs1_n != !alt) cs_bad++;
        if (ide_da != addr[3:1]) da_bad++;
      end
      if (ide_dd_oe) begin
        if (oe_first < 0) oe_first = idx;
        oe_cnt++;
        if (ide_dd_out != wd[15:0]) dout_bad++;
      end
      ide_dd_in = 16'($urandom);
      if (!we && !ide_dior_n) last_v = ide_dd_in;
      ide_iordy = !(w > 0 && idx >= s + p - 1 && idx < s + p - 1 + w);
      if (midcfg && idx == 2) begin
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = nset[7:0];
      end else if (midcfg && idx == 3) begin
        cfg_sel = 2'd1; cfg_wdata = npul[7:0];
      end else if (midcfg && idx == 4) begin
        cfg_sel = 2'd2; cfg_wdata = ncyc[7:0];
      end else begin
        cfg_we = 1'b0;
      end
      idx++;
    end
    ide_iordy = 1'b1;
    cfg_we = 1'b0;
    chk(stb_first == s, "R2 strobe start", stb_first, s);
    chk(stb_cnt == p + w, w > 0 ? "R9 stretched strobe" : "R3 strobe width", stb_cnt, p + w);
    chk(ack_idx == c + w, w > 0 ? "R9 stretched ack" : "R4 ack cycle", ack_idx, c + w);
    chk(cs_first == 1, "R5 cs start", cs_first, 1);
    chk(cs_cnt == c - 2 + w, "R5 cs width", cs_cnt, c - 2 + w);
    chk(cs_bad == 0, "R6 window select", cs_bad, 0);
    chk(da_bad == 0, "R7 register address", da_bad, 0);
    chk(wrong == 0, "R13 other strobe", wrong, 0);
    if (we) begin
      chk(oe_first == s, "R10 drive start", oe_first, s);
      chk(oe_cnt == c - 1 + w - s, "R10 drive length", oe_cnt, c - 1 + w - s);
      chk(dout_bad == 0, "R10 write data", dout_bad, 0);
    end else begin
      chk(oe_cnt == 0, "R10 read drives bus", oe_cnt, 0);
      @(negedge clk);
      chk(host_rdata == last_v, "R8 read capture", host_rdata, last_v);
      chk(host_ack == 1'b0, "R12 single ack", host_ack, 0);
    end
    if (midcfg) begin
      m_set = nset; m_pul = npul; m_cyc = ncyc;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle pins after reset
    chk(ide_cs0_n && ide_cs1_n, "R1 cs idle", {ide_cs0_n, ide_cs1_n}, 3);
    chk(ide_dior_n && ide_diow_n, "R1 strobes idle", {ide_dior_n, ide_diow_n}, 3);
    chk(!ide_dd_oe && !host_ack, "R1 bus/ack idle", {ide_dd_oe, host_ack}, 0);
    // R1: reset timing (18/73/150 cycles) via a full access
    access(1'b0, 22'h00000E, 0, 0, 1'b0);
    // R6 alternate window, index 6, write
    access(1'b1, (1 << 21) | (6 << 1), 16'h00A5, 0, 1'b0);
    // R3: pulse 0 behaves as 1; R4: short cycle is raised
    cfg_write(0, 0); cfg_write(1, 0); cfg_write(2, 0);
    access(1'b0, 22'h000004, 0, 0, 1'b0);
    // R4: long programmed cycle kept
    cfg_write(0, 2); cfg_write(1, 3); cfg_write(2, 20);
    access(1'b1, 22'h00000A, 16'h1234, 0, 1'b0);
    // R11: select 3 ignored
    cfg_write(3, 9);
    access(1'b0, (1 << 21) | 12, 0, 0, 1'b0);
    // R9: ready stall
    access(1'b0, 22'h000002, 0, 3, 1'b0);
    access(1'b1, 22'h00000C, 16'hBEEF, 2, 1'b0);
    // R11: timing writes mid-access, then next access uses them
    access(1'b0, 22'h000006, 0, 0, 1'b1);
    access(1'b1, 22'h000008, 16'h5A5A, 0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      cfg_write(0, $urandom_range(0, 6));
      cfg_write(1, $urandom_range(0, 8));
      cfg_write(2, $urandom_range(0, 25));
      access(1'($urandom_range(0, 1)),
             ($urandom_range(0, 1) << 21) | ($urandom_range(0, 7) << 1),
             $urandom_range(0, 65535), $urandom_range(0, 4),
             1'($urandom_range(0, 3) == 0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule